// File: doc/BRIEF.md
# Host-Controlled Gate Output Logic

This block lets an external host drive one bit of an 8-bit local port directly, with no action from the local processor. Until it is armed, every host write to the buffer interface is forwarded to the local controller, and local port writes set all port bits. A one-cycle pulse on `armPulse` from the local controller arms the feature. Once armed, it stays armed until reset.

While armed, the block watches host writes. A command write (`hostA0` = 1) of the configured command code starts a pending sequence, and that write is held back from the local controller. The next data write (`hostA0` = 0) is also held back. The selected bit of its data sets the dedicated gate bit of the port. Local writes still drive every other port bit. The gate bit stays readable through `portRd`, but local writes can no longer change it.

Top module: `host_gate_out`

## Requirements
- R1: After reset `portOut` is 8'hFF, `fwdValid` is 0 and the block is not armed.
- R2: While not armed, each host write appears on `fwdValid`/`fwdIsCmd`/`fwdData` in the cycle after the write. A local write sets all eight port bits, gate bit 1 included, in the cycle after the write.
- R3: A pulse on `armPulse` arms the block. It stays armed whatever further pulses arrive, and only reset disarms it.
- R4: While armed, a local write updates port bits 0 and 2 to 7 but leaves bit 1 unchanged.
- R5: While armed, a host command write (`hostA0` = 1) of 8'hD1 is not forwarded (`fwdValid` stays 0), and it makes a sequence pending.
- R6: While a sequence is pending, the next host data write (`hostA0` = 0) is not forwarded. Bit 1 of its data becomes `portOut[1]` in the cycle after it, and the sequence ends.
- R7: While a sequence is pending, a host command write of any value other than 8'hD1 cancels the sequence and is forwarded. A following data write is forwarded and leaves `portOut[1]` unchanged.
- R8: A repeated 8'hD1 command while a sequence is pending is also not forwarded, and the sequence stays pending.
- R9: While armed with no sequence pending, a host data write is forwarded normally and leaves `portOut[1]` unchanged.
- R10: `portRd` always equals the current port level, including the gate bit.
- R11: If a gate-setting data write and a local write land in the same cycle, bit 1 comes from the host data and the other bits come from the local data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armPulse | input | 1 | Local one-way arm pulse |
| hostWr | input | 1 | Host write strobe, one cycle per write |
| hostA0 | input | 1 | Host address bit: 1 = command, 0 = data |
| hostData | input | 8 | Host write byte |
| localWr | input | 1 | Local port write strobe |
| localData | input | 8 | Local port write value |
| portOut | output | 8 | Port output levels |
| portRd | output | 8 | Local read-back of the port |
| fwdValid | output | 1 | Forwarded host write strobe to the local controller |
| fwdIsCmd | output | 1 | Address bit of the forwarded write |
| fwdData | output | 8 | Data of the forwarded write |

## Verification
The bench builds the block with its default parameters: an 8-bit port, gate bit 1 and command code 8'hD1. Directed sequences cover these cases:
- arming, and re-arming pulses that must have no effect;
- command cancellation, repeated command bytes and lone data writes;
- a host gate update colliding with a local write;
- disarming by a mid-run reset.

The random phase biases host command bytes toward 8'hD1 so that pending, cancelled and completed sequences occur often. Because the random phase pulses `armPulse` only rarely, long stretches run both unarmed and armed.

// File: rtl/host_gate_pkg.sv
package host_gate_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic fwdStb;      // forward current host write to local side
    logic gateLoad;    // load gate bit from host data
    logic gateLocalEn; // local write may touch gate bit
    logic portLocalWr; // local write to other port bits
  } gateStrb_t;

endpackage

// File: rtl/host_gate_ctrl.sv
module host_gate_ctrl
  import host_gate_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_CODE = 8'hD1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armPulse,
  input  logic              hostWr,
  input  logic              hostA0,
  input  logic [DATA_W-1:0] hostData,
  input  logic              localWr,
  output gateStrb_t         strb
);

  logic armed;
  logic pending;
  logic isGateCmd;
  logic isHostData;

  assign isGateCmd  = hostWr && hostA0 && (hostData == CMD_CODE);
  assign isHostData = hostWr && !hostA0;

  always_comb begin
    strb.fwdStb      = hostWr && !(armed && (isGateCmd || (pending && isHostData)));
    strb.gateLoad    = armed && pending && isHostData;
    strb.gateLocalEn = localWr && !armed;
    strb.portLocalWr = localWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (armPulse) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !armed) begin
      pending <= 1'b0;
    end else if (hostWr) begin
      pending <= hostA0 && (hostData == CMD_CODE);
    end
  end

  // R3
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);

  // R5
  pend_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> armed);

  // R5
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(hostWr && hostA0));

  // R6
  load_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.gateLoad |=> !pending);

endmodule

// File: rtl/host_gate_dp.sv
module host_gate_dp
  import host_gate_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int DATA_W = 8,
  parameter int GATE_BIT = 1,
  parameter logic [PORT_W-1:0] RST_VAL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrb_t         strb,
  input  logic              hostA0,
  input  logic [DATA_W-1:0] hostData,
  input  logic [PORT_W-1:0] localData,
  output logic [PORT_W-1:0] portQ,
  output logic              fwdValid,
  output logic              fwdIsCmd,
  output logic [DATA_W-1:0] fwdData
);

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    if (i == GATE_BIT) begin : g_gate
      always_ff @(posedge clk) begin
        if (!rstN) begin
          portQ[i] <= RST_VAL[i];
        end else if (strb.gateLoad) begin
          portQ[i] <= hostData[GATE_BIT];
        end else if (strb.gateLocalEn) begin
          portQ[i] <= localData[i];
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN) begin
          portQ[i] <= RST_VAL[i];
        end else if (strb.portLocalWr) begin
          portQ[i] <= localData[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdIsCmd <= 1'b0;
      fwdData  <= '0;
    end else begin
      fwdValid <= strb.fwdStb;
      if (strb.fwdStb) begin
        fwdIsCmd <= hostA0;
        fwdData  <= hostData;
      end
    end
  end

  // R4
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.gateLoad && !strb.gateLocalEn) |=> $stable(portQ[GATE_BIT]));

  // R2
  fwd_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fwdStb |=> fwdValid);

  // R5
  fwd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.fwdStb |=> !fwdValid);

endmodule

// File: rtl/host_gate_out.sv
module host_gate_out
  import host_gate_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int DATA_W = 8,
  parameter int GATE_BIT = 1,
  parameter logic [DATA_W-1:0] CMD_CODE = 8'hD1,
  parameter logic [PORT_W-1:0] RST_VAL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armPulse,
  input  logic              hostWr,
  input  logic              hostA0,
  input  logic [DATA_W-1:0] hostData,
  input  logic              localWr,
  input  logic [PORT_W-1:0] localData,
  output logic [PORT_W-1:0] portOut,
  output logic [PORT_W-1:0] portRd,
  output logic              fwdValid,
  output logic              fwdIsCmd,
  output logic [DATA_W-1:0] fwdData
);

  gateStrb_t strb;

  host_gate_ctrl #(
    .DATA_W  (DATA_W),
    .CMD_CODE(CMD_CODE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .armPulse(armPulse),
    .hostWr  (hostWr),
    .hostA0  (hostA0),
    .hostData(hostData),
    .localWr (localWr),
    .strb    (strb)
  );

  host_gate_dp #(
    .PORT_W  (PORT_W),
    .DATA_W  (DATA_W),
    .GATE_BIT(GATE_BIT),
    .RST_VAL (RST_VAL)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .hostA0   (hostA0),
    .hostData (hostData),
    .localData(localData),
    .portQ    (portOut),
    .fwdValid (fwdValid),
    .fwdIsCmd (fwdIsCmd),
    .fwdData  (fwdData)
  );

  // R10: read-back is the live port level
  assign portRd = portOut;

endmodule

// File: tb/host_gate_out_test.sv
module host_gate_out_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CMD = 8'hD1;

  logic       clk = 1'b0;
  logic       rstN;
  logic       armPulse, hostWr, hostA0, localWr;
  logic [7:0] hostData, localData;
  logic [7:0] portOut, portRd, fwdData;
  logic       fwdValid, fwdIsCmd;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // model state
  bit       mArmed, mPend;
  bit [7:0] mPort;
  bit       eFwd, eIsCmd;
  bit [7:0] eData;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_gate_out uut (
    .clk(clk), .rstN(rstN), .armPulse(armPulse), .hostWr(hostWr),
    .hostA0(hostA0), .hostData(hostData), .localWr(localWr),
    .localData(localData), .portOut(portOut), .portRd(portRd),
    .fwdValid(fwdValid), .fwdIsCmd(fwdIsCmd), .fwdData(fwdData)
  );

  function automatic bit expFwd(bit wr, bit a0, bit [7:0] d);
    return wr && !(mArmed && ((a0 && d == CMD) || (mPend && !a0)));
  endfunction

  function automatic bit [7:0] expPort(bit wr, bit a0, bit [7:0] d, bit lw, bit [7:0] ld);
    bit [7:0] p = mPort;
    if (lw) p = {ld[7:2], p[1], ld[0]};
    if (wr && mArmed && mPend && !a0) p[1] = d[1];
    else if (lw && !mArmed) p[1] = ld[1];
    return p;
  endfunction

  task automatic chk8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    armPulse = 0; hostWr = 0; hostA0 = 0; hostData = 0;
    localWr = 0; localData = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    idle();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rstN = 1;
    mArmed = 0; mPend = 0; mPort = 8'hFF;
    eFwd = 0; eIsCmd = 0; eData = 0;
  endtask

  task automatic step(string tag, bit arm, bit wr, bit a0, bit [7:0] d, bit lw, bit [7:0] ld);
    @(negedge clk);
    armPulse = arm; hostWr = wr; hostA0 = a0; hostData = d;
    localWr = lw; localData = ld;
    @(posedge clk);
    #1;
    eFwd = expFwd(wr, a0, d);
    if (eFwd) begin eIsCmd = a0; eData = d; end
    mPort = expPort(wr, a0, d, lw, ld);
    if (!mArmed) mPend = 0;
    else if (wr) mPend = a0 && (d == CMD);
    if (arm) mArmed = 1;
    idle();
    chk8(tag, "portOut", portOut, mPort);
    chk8("R10", "portRd", portRd, mPort);
    chk8(tag, "fwdValid", {7'd0, fwdValid}, {7'd0, eFwd});
    if (eFwd) begin
      chk8(tag, "fwdData", fwdData, eData);
      chk8(tag, "fwdIsCmd", {7'd0, fwdIsCmd}, {7'd0, eIsCmd});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0;
    idle();
    doReset();
    // R1 reset state
    chk8("R1", "portOut", portOut, 8'hFF);
    chk8("R1", "fwdValid", {7'd0, fwdValid}, 8'd0);

    // R2 unarmed: local write touches gate bit, host writes forwarded
    step("R2", 0, 0, 0, 8'h00, 1, 8'h00);
    step("R2", 0, 1, 1, CMD,   0, 8'h00);
    step("R2", 0, 1, 0, 8'h02, 0, 8'h00);
    chk8("R2", "gate bit unarmed", {7'd0, portOut[1]}, 8'd0);

    // R3 arm, R4 local write cannot move gate bit
    step("R3", 1, 0, 0, 8'h00, 0, 8'h00);
    step("R4", 0, 0, 0, 8'h00, 1, 8'hFF);
    chk8("R4", "portOut armed local", portOut, 8'hFD);

    // R5/R6 full sequence
    step("R5", 0, 1, 1, CMD,   0, 8'h00);
    step("R6", 0, 1, 0, 8'h02, 0, 8'h00);
    chk8("R6", "gate set", portOut, 8'hFF);

    // R7 cancel
    step("R5", 0, 1, 1, CMD,   0, 8'h00);
    step("R7", 0, 1, 1, 8'h55, 0, 8'h00);
    step("R7", 0, 1, 0, 8'h00, 0, 8'h00);
    chk8("R7", "gate kept", {7'd0, portOut[1]}, 8'd1);

    // R8 repeated command stays pending
    step("R8", 0, 1, 1, CMD,   0, 8'h00);
    step("R8", 0, 1, 1, CMD,   0, 8'h00);
    step("R8", 0, 1, 0, 8'h00, 0, 8'h00);
    chk8("R8", "gate cleared", {7'd0, portOut[1]}, 8'd0);

    // R9 lone data write
    step("R9", 0, 1, 0, 8'h02, 0, 8'h00);
    chk8("R9", "gate kept", {7'd0, portOut[1]}, 8'd0);

    // R11 collision
    step("R5",  0, 1, 1, CMD,   0, 8'h00);
    step("R11", 0, 1, 0, 8'h02, 1, 8'h00);
    chk8("R11", "collision", portOut, 8'h02);

    // R3 extra pulse no effect, reset disarms
    step("R3", 1, 0, 0, 8'h00, 1, 8'h00);
    chk8("R3", "still armed", {7'd0, portOut[1]}, 8'd1);
    doReset();
    chk8("R1", "portOut after reset", portOut, 8'hFF);
    step("R3", 0, 0, 0, 8'h00, 1, 8'h00);
    chk8("R3", "disarmed by reset", portOut, 8'h00);

    // random phase
    void'($urandom(32'd4242));
    for (int n = 0; n < 4000; n++) begin
      bit arm = ($urandom % 300) == 0;
      bit wr  = ($urandom % 2) == 0;
      bit a0  = ($urandom % 2) == 0;
      bit [7:0] d = (a0 && ($urandom % 2)) ? CMD : 8'($urandom);
      bit lw  = ($urandom % 3) == 0;
      bit [7:0] ld = 8'($urandom);
      step(mArmed ? "R6" : "R2", arm, wr, a0, d, lw, ld);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule